// File: doc/BRIEF.md
# SMI Source Gating Register File

This block is a byte-addressed power-management configuration register file that decides which events may raise a system-management interrupt. Software programs it through a simple write/read port: an address, a write strobe, write data and a combinational read-data output that follows the address. Most locations are plain storage. A handful have masked writes, write-one-to-clear behaviour or read values that are replaced.

Three gates come out of the stored bits. Each gate is the AND of one global SMI enable bit (bit 3 of location 0x77) with per-source bits held elsewhere. The gates cover the real-time-clock interrupt, the APM port and the interrupt-8 SMI mask. The block watches the clock interrupt request. On a rising edge while the clock gate is open, it emits a one-cycle SMI request and sets a sticky status flag. The flag stays set until one of three things happens: software writes a one to its bit, the clock gate closes, or the block is reset.

Top module: `pmu_smi_ctrl`

## Requirements
- R1: After synchronous active-low reset, every location reads 0x00 except 0x7F, which reads 0x80. The status flag, the SMI request and all three gate outputs are 0.
- R2: A write to 0x40 keeps only data bits 4..0 (mask 0x1F). A write to 0x41 keeps only bit 4 (mask 0x10). A write to 0x77 keeps all eight bits. Any location without a special meaning stores the full byte and reads it back.
- R3: A write to 0x42 clears each stored bit 4..0 whose data bit is one and leaves the other bits unchanged. A one in data bit 3 also clears the clock SMI status flag. A zero in bit 3 leaves the flag alone.
- R4: The clock gate `rtc_smi_en` is high exactly when 0x77 bit 3 and 0x40 bit 3 are both set. It follows every write to either location.
- R5: A rising edge of `rtc_irq` sampled while the clock gate is open makes `smi_req` high for exactly the next cycle and sets `rtc_smi_sts`. Holding `rtc_irq` high does not retrigger.
- R6: A rising edge of `rtc_irq` while the clock gate is closed raises no request and leaves the flag at 0.
- R7: The status flag is 0 from the same clock edge at which a write closes the clock gate. Reopening the gate does not bring the flag back.
- R8: A read of 0x42 returns the stored byte with bit 3 replaced by the status flag.
- R9: A read of 0x43 returns 0x10 when `soft_smi_sts` is high and 0x00 when it is low. A read of 0x7F always returns 0x80. Writes to these two locations do not change what they read.
- R10: `apm_smi_en` is high exactly when 0x77 bit 3 and 0x41 bit 4 are both set.
- R11: `irq8_smi_open` is high exactly when 0x77 bit 3 is set and 0x40 bit 0 or bit 1 is set.
- R12: If a qualifying clock event and a write-one-to-clear of bit 3 fall in the same cycle, the event wins: the flag ends set and the request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_addr | input | ADDR_W | Register address, used for both write and read |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data for `cfg_addr`, combinational |
| rtc_irq | input | 1 | Clock interrupt request level; its rising edge is the event |
| soft_smi_sts | input | 1 | Software SMI status, reflected at 0x43 |
| smi_req | output | 1 | One-cycle SMI request pulse |
| rtc_smi_sts | output | 1 | Sticky clock SMI status flag |
| rtc_smi_en | output | 1 | Clock SMI gate |
| apm_smi_en | output | 1 | APM SMI gate |
| irq8_smi_open | output | 1 | Interrupt-8 SMI mask open |

## Verification
The bench builds the block with its default 8-bit address and 8-bit data. At those sizes every special location (0x40–0x43, 0x77, 0x7F) and the top address 0xFF can be reached by direct writes and reads. A table of write-then-readback vectors exercises the write masks and the replaced reads. Directed sequences then cover the gate outputs and the clock event with the gate open and closed. They also check the flag being cleared by closing the gate and by write-one-to-clear, the same-cycle set-versus-clear race, and a reset in the middle of the run.

// File: rtl/pmu_smi_pkg.sv
// Package: shared constants and types for the SMI gating register file.
// Assumes 8-bit locations; the special addresses below are fixed by software.
package pmu_smi_pkg;
    localparam int unsigned CFG_AW = 8;
    localparam int unsigned CFG_DW = 8;

    // Special locations
    localparam logic [7:0] ADR_SRC_EN = 8'h40;  // per-source enables
    localparam logic [7:0] ADR_APM_EN = 8'h41;  // APM enable
    localparam logic [7:0] ADR_STS    = 8'h42;  // status, write-one-to-clear
    localparam logic [7:0] ADR_SOFT   = 8'h43;  // soft SMI status view
    localparam logic [7:0] ADR_GLOBAL = 8'h77;  // global control
    localparam logic [7:0] ADR_ID     = 8'h7F;  // constant read

    // Write masks and fixed read values
    localparam logic [7:0] MSK_SRC_EN = 8'h1F;
    localparam logic [7:0] MSK_APM_EN = 8'h10;
    localparam logic [7:0] MSK_W1C    = 8'h1F;
    localparam logic [7:0] VAL_SOFT   = 8'h10;
    localparam logic [7:0] VAL_ID     = 8'h80;

    // Bit positions
    localparam int unsigned BIT_GLOBAL = 3;  // in 0x77
    localparam int unsigned BIT_RTC    = 3;  // in 0x40 and 0x42
    localparam int unsigned BIT_APM    = 4;  // in 0x41
    localparam int unsigned BIT_IRQ8_A = 0;  // in 0x40
    localparam int unsigned BIT_IRQ8_B = 1;  // in 0x40

    typedef struct packed {
        logic rtc;
        logic apm;
        logic irq8;
    } smi_gate_t;
endpackage

// File: rtl/pmu_cfg_regs.sv
// Module: storage for all locations, with masked and write-one-to-clear
// writes, and the SMI gates decoded from the stored bits.
// Assumes DATA_W >= 8 and ADDR_W >= 7 so that the special locations exist.
module pmu_cfg_regs
    import pmu_smi_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_AW,
    parameter int unsigned DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] raw_rd,
    output smi_gate_t         gate,
    output logic              rtc_en_nxt
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] I_SRC = ADDR_W'(ADR_SRC_EN);
    localparam logic [ADDR_W-1:0] I_APM = ADDR_W'(ADR_APM_EN);
    localparam logic [ADDR_W-1:0] I_STS = ADDR_W'(ADR_STS);
    localparam logic [ADDR_W-1:0] I_GLB = ADDR_W'(ADR_GLOBAL);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] src_nxt;
    logic [DATA_W-1:0] glb_nxt;

    // Value a write would leave at the addressed location
    always_comb begin
        unique case (addr)
            I_SRC:   wr_val = wdata & DATA_W'(MSK_SRC_EN);
            I_APM:   wr_val = wdata & DATA_W'(MSK_APM_EN);
            I_STS:   wr_val = mem[addr] & ~(wdata & DATA_W'(MSK_W1C));
            default: wr_val = wdata;
        endcase
    end

    // Storage update with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (wr) begin
            mem[addr] <= wr_val;
        end
    end

    // Post-write view of the two locations that gate the clock source
    always_comb begin
        src_nxt = (wr && addr == I_SRC) ? wr_val : mem[I_SRC];
        glb_nxt = (wr && addr == I_GLB) ? wr_val : mem[I_GLB];
        if (!rst_n) begin
            src_nxt = '0;
            glb_nxt = '0;
        end
    end

    // Gate decode from the stored bits
    always_comb begin
        gate.rtc   = mem[I_GLB][BIT_GLOBAL] & mem[I_SRC][BIT_RTC];
        gate.apm   = mem[I_GLB][BIT_GLOBAL] & mem[I_APM][BIT_APM];
        gate.irq8  = mem[I_GLB][BIT_GLOBAL] &
                     (mem[I_SRC][BIT_IRQ8_A] | mem[I_SRC][BIT_IRQ8_B]);
        rtc_en_nxt = glb_nxt[BIT_GLOBAL] & src_nxt[BIT_RTC];
        raw_rd     = mem[addr];
    end
endmodule

// File: rtl/pmu_rtc_smi.sv
// Module: clock-interrupt SMI path. Detects the rising edge of the request,
// issues a one-cycle SMI pulse and keeps a sticky status flag.
// Assumes en_nxt is the gate as it will be after the current edge.
module pmu_rtc_smi (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic en_cur,
    input  logic en_nxt,
    input  logic clr_w1c,
    output logic smi_pulse,
    output logic sts
);
    logic irq_q;
    logic hit;

    // Qualified rising edge of the request
    always_comb hit = irq & ~irq_q & en_cur & en_nxt;

    // Edge-detect history
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq;
    end

    // Sticky flag: closing the gate wins, then a new event, then W1C
    always_ff @(posedge clk) begin
        if (!rst_n)       sts <= 1'b0;
        else if (!en_nxt) sts <= 1'b0;
        else if (hit)     sts <= 1'b1;
        else if (clr_w1c) sts <= 1'b0;
    end

    // One-cycle request
    always_ff @(posedge clk) begin
        if (!rst_n) smi_pulse <= 1'b0;
        else        smi_pulse <= hit;
    end
endmodule

// File: rtl/pmu_rd_mux.sv
// Module: read-data selection; replaces the value for special locations.
// Assumes DATA_W >= 8.
module pmu_rd_mux
    import pmu_smi_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_AW,
    parameter int unsigned DATA_W = CFG_DW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] raw,
    input  logic              rtc_sts,
    input  logic              soft_sts,
    output logic [DATA_W-1:0] rdata
);
    // Per-address read value
    always_comb begin
        rdata = raw;
        unique case (addr)
            ADDR_W'(ADR_STS):  rdata[BIT_RTC] = rtc_sts;
            ADDR_W'(ADR_SOFT): rdata = soft_sts ? DATA_W'(VAL_SOFT) : '0;
            ADDR_W'(ADR_ID):   rdata = DATA_W'(VAL_ID);
            default:           rdata = raw;
        endcase
    end
endmodule

// File: rtl/pmu_smi_ctrl.sv
// Module: top of the SMI gating register file. Ties storage, the clock SMI
// path and the read selection together.
// Assumes a single clock and synchronous active-low reset.
module pmu_smi_ctrl
    import pmu_smi_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_AW,
    parameter int unsigned DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              rtc_irq,
    input  logic              soft_smi_sts,
    output logic              smi_req,
    output logic              rtc_smi_sts,
    output logic              rtc_smi_en,
    output logic              apm_smi_en,
    output logic              irq8_smi_open
);
    logic [DATA_W-1:0] raw_rd;
    smi_gate_t         gate;
    logic              rtc_en_nxt;
    logic              clr_w1c;

    pmu_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .raw_rd     (raw_rd),
        .gate       (gate),
        .rtc_en_nxt (rtc_en_nxt)
    );

    // Write-one-to-clear request for the clock status bit
    always_comb clr_w1c = cfg_wr && (cfg_addr == ADDR_W'(ADR_STS)) && cfg_wdata[BIT_RTC];

    pmu_rtc_smi u_rtc (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (rtc_irq),
        .en_cur    (gate.rtc),
        .en_nxt    (rtc_en_nxt),
        .clr_w1c   (clr_w1c),
        .smi_pulse (smi_req),
        .sts       (rtc_smi_sts)
    );

    pmu_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr     (cfg_addr),
        .raw      (raw_rd),
        .rtc_sts  (rtc_smi_sts),
        .soft_sts (soft_smi_sts),
        .rdata    (cfg_rdata)
    );

    // Gate outputs
    always_comb begin
        rtc_smi_en    = gate.rtc;
        apm_smi_en    = gate.apm;
        irq8_smi_open = gate.irq8;
    end
endmodule

// File: rtl/pmu_smi_ctrl_chk.sv
// Module: temporal checks on the top-level ports, bound into pmu_smi_ctrl.
module pmu_smi_ctrl_chk
    import pmu_smi_pkg::*;
#(
    parameter int unsigned ADDR_W = CFG_AW,
    parameter int unsigned DATA_W = CFG_DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              rtc_irq,
    input logic              soft_smi_sts,
    input logic              smi_req,
    input logic              rtc_smi_sts,
    input logic              rtc_smi_en,
    input logic              apm_smi_en,
    input logic              irq8_smi_open
);
    // A request always comes with the flag set
    assert_req_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> rtc_smi_sts);

    // A request lasts one cycle
    assert_req_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);

    // A request needs the gate open and the request line high one cycle earlier
    assert_req_needs_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> ($past(rtc_irq) && $past(rtc_smi_en)));

    // A closed gate never shows a set flag
    assert_flag_off_when_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_smi_en |-> !rtc_smi_sts);

    // The flag only falls after a register write
    assert_flag_falls_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtc_smi_sts) |-> $past(cfg_wr));

    // The APM gate only opens after a register write
    assert_apm_opens_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apm_smi_en) |-> $past(cfg_wr));

    // The interrupt-8 mask only opens after a register write
    assert_irq8_opens_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq8_smi_open) |-> $past(cfg_wr));

    // Fixed read locations
    assert_id_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(ADR_ID)) |-> (cfg_rdata == DATA_W'(VAL_ID)));

    assert_soft_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(ADR_SOFT)) |->
        (cfg_rdata == (soft_smi_sts ? DATA_W'(VAL_SOFT) : DATA_W'(0))));

    // Read of the status location shows the flag at bit 3
    assert_sts_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(ADR_STS)) |-> (cfg_rdata[BIT_RTC] == rtc_smi_sts));

    logic unused_ok;
    always_comb unused_ok = ^cfg_wdata;
endmodule

bind pmu_smi_ctrl pmu_smi_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .rtc_irq       (rtc_irq),
    .soft_smi_sts  (soft_smi_sts),
    .smi_req       (smi_req),
    .rtc_smi_sts   (rtc_smi_sts),
    .rtc_smi_en    (rtc_smi_en),
    .apm_smi_en    (apm_smi_en),
    .irq8_smi_open (irq8_smi_open)
);

// File: tb/test_pmu_smi_ctrl.sv
module test_pmu_smi_ctrl;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;
    localparam int NVEC = 13;
    // {address, write data, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h40, 8'hFF, 8'h1F}, {8'h40, 8'hE8, 8'h08},
        {8'h41, 8'hFF, 8'h10}, {8'h41, 8'hEF, 8'h00},
        {8'h77, 8'hA5, 8'hA5}, {8'h77, 8'h00, 8'h00},
        {8'h10, 8'h5A, 8'h5A}, {8'hFF, 8'hC3, 8'hC3},
        {8'h00, 8'h81, 8'h81}, {8'h7F, 8'h00, 8'h80},
        {8'h7F, 8'h12, 8'h80}, {8'h43, 8'hFF, 8'h00},
        {8'h42, 8'hFF, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          rtc_irq = 1'b0;
    logic          soft_smi_sts = 1'b0;
    logic          smi_req, rtc_smi_sts, rtc_smi_en, apm_smi_en, irq8_smi_open;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [DW-1:0] rv;

    always #2.5 clk = ~clk;

    pmu_smi_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_pmu_smi_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rtc_irq(rtc_irq),
        .soft_smi_sts(soft_smi_sts), .smi_req(smi_req), .rtc_smi_sts(rtc_smi_sts),
        .rtc_smi_en(rtc_smi_en), .apm_smi_en(apm_smi_en), .irq8_smi_open(irq8_smi_open)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic irq_edge(input string req, input logic exp);
        @(negedge clk);
        rtc_irq = 1'b1;
        @(negedge clk);
        check(req, {7'd0, smi_req}, {7'd0, exp});
        check(req, {7'd0, rtc_smi_sts}, {7'd0, exp});
        @(negedge clk);
        check(req, {7'd0, smi_req}, 8'h00);  // held level: no second request
        rtc_irq = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 smi_req", {7'd0, smi_req}, 8'h00);
        check("R1 sts", {7'd0, rtc_smi_sts}, 8'h00);
        check("R1 gates", {5'd0, rtc_smi_en, apm_smi_en, irq8_smi_open}, 8'h00);
        rd(8'h40, rv); check("R1 0x40", rv, 8'h00);
        rd(8'h77, rv); check("R1 0x77", rv, 8'h00);
        rd(8'h7F, rv); check("R1 0x7F", rv, 8'h80);

        // R2 / R9 / R3: write masks and replaced reads
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], rv);
            check("R2 R9 R3 table", rv, VEC[i][7:0]);
        end

        // R4 / R10 / R11 gate decode (0x40 holds 0x08 here)
        wr(8'h77, 8'h08);
        @(negedge clk); check("R4 rtc gate", {7'd0, rtc_smi_en}, 8'h01);
        check("R10 apm closed", {7'd0, apm_smi_en}, 8'h00);
        wr(8'h41, 8'h10);
        @(negedge clk); check("R10 apm open", {7'd0, apm_smi_en}, 8'h01);
        check("R11 irq8 closed", {7'd0, irq8_smi_open}, 8'h00);
        wr(8'h40, 8'h09);
        @(negedge clk); check("R11 irq8 bit0", {7'd0, irq8_smi_open}, 8'h01);
        wr(8'h40, 8'h0A);
        @(negedge clk); check("R11 irq8 bit1", {7'd0, irq8_smi_open}, 8'h01);
        wr(8'h40, 8'h08);
        @(negedge clk); check("R11 irq8 off", {7'd0, irq8_smi_open}, 8'h00);
        check("R4 rtc still", {7'd0, rtc_smi_en}, 8'h01);

        // R5 event, R8 status read
        irq_edge("R5 event", 1'b1);
        rd(8'h42, rv); check("R8 sts read", rv, 8'h08);
        // R3: zero in bit 3 keeps the flag, one clears it
        wr(8'h42, 8'hF7);
        rd(8'h42, rv); check("R3 keep", rv, 8'h08);
        wr(8'h42, 8'h08);
        rd(8'h42, rv); check("R3 clear", rv, 8'h00);

        // R6 event with the gate closed
        wr(8'h77, 8'h00);
        irq_edge("R6 closed", 1'b0);

        // R7 closing the gate clears the flag at once
        wr(8'h77, 8'h08);
        irq_edge("R7 set", 1'b1);
        wr(8'h40, 8'h00);
        check("R7 cleared", {7'd0, rtc_smi_sts}, 8'h00);
        check("R4 closed", {7'd0, rtc_smi_en}, 8'h00);
        wr(8'h40, 8'h08);
        @(negedge clk); check("R7 stays", {7'd0, rtc_smi_sts}, 8'h00);

        // R12 event and clear in the same cycle
        @(negedge clk);
        cfg_addr = 8'h42; cfg_wdata = 8'h08; cfg_wr = 1'b1; rtc_irq = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R12 flag", {7'd0, rtc_smi_sts}, 8'h01);
        check("R12 req", {7'd0, smi_req}, 8'h01);
        rtc_irq = 1'b0;

        // R9 soft status view
        soft_smi_sts = 1'b1;
        rd(8'h43, rv); check("R9 soft hi", rv, 8'h10);
        soft_smi_sts = 1'b0;
        rd(8'h43, rv); check("R9 soft lo", rv, 8'h00);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 sts after", {7'd0, rtc_smi_sts}, 8'h00);
        rd(8'h77, rv); check("R1 0x77 after", rv, 8'h00);
        rd(8'h41, rv); check("R1 0x41 after", rv, 8'h00);
        rd(8'hFF, rv); check("R1 0xFF after", rv, 8'h00);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule